// File: doc/BRIEF.md
# SDRAM Refresh and Power-Mode Sequencer

This block sits on the controller side of a two-bank, 16-bit SDRAM. It owns the clock-enable pin and the chip-select, row-strobe, column-strobe and write-enable command pins whenever the memory is being refreshed or put to sleep. It issues auto-refresh commands when an internal interval counter says one is due or when the controller asks for one. On request it puts the memory into either a shallow power-down state or a self-refresh state, and brings it back on a wake request.

Each of the three clock-enable-related modes has its own rules. Auto refresh needs the banks precharged and then blocks further commands for the row-cycle time. Power down needs the banks settled for the precharge time, holds clock enable low, and leaves after a single clock. Self refresh has the same entry condition, lets the memory refresh itself, and needs a full row-cycle time after exit. A refresh that falls due while the memory is powered down forces it awake so the deadline is kept. A `ready` output tells the access controller when it may issue commands again. All timing values are parameters in clock cycles.

Top module: `sdram_pwr_seq`

## Requirements
- R1: During reset `cke`=1, `cs_n`=1, `ras_n`=1, `cas_n`=1, `we_n`=1 and `ready`=0. After reset `cs_n` is 0 on every cycle.
- R2: A cycle with no command carries the NOP encoding (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1). While `cke` stays low from one cycle to the next, the pins carry NOP.
- R3: Auto refresh is the encoding `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1 with `cke`=1. If `ref_req` is high at an edge while the block is idle and settled, the command appears after that edge. If `ref_req` arrives while the block is busy, it is held and issued after the first edge that finds the block idle.
- R4: After an auto refresh appears on the pins, `ready` stays low for exactly `T_RC` cycles. No further auto refresh appears within `T_RC` cycles.
- R5: With no other activity and the banks settled, an auto refresh is issued every `T_REFI` cycles. The first one comes `T_REFI` edges after reset release.
- R6: Power-down entry (`pd_req`=1, `pd_deep`=0) drops `cke` after the next edge with NOP on the pins. It happens only when `banks_idle` has been high for at least `T_RP` consecutive edges and no refresh is pending. When `banks_idle` and `pd_req` rise together, `cke` falls `T_RP`+1 edges later.
- R7: In power down, `wake_req` raises `cke` after the next edge. `ready` rises one cycle after that.
- R8: A refresh falling due during power down forces an exit. `cke` rises `T_REFI` cycles after the previous auto refresh, and the next auto refresh follows two cycles later.
- R9: Self-refresh entry (`pd_req`=1, `pd_deep`=1) drives one cycle of the refresh encoding with `cke`=0, then NOP with `cke`=0. Neither the refresh interval nor `ref_req` wakes the block from this state.
- R10: In self refresh, `wake_req` raises `cke` after the next edge. `ready` rises exactly `T_RC` cycles after `cke` rises. The refresh interval restarts at that exit, so the next self-initiated auto refresh comes `T_REFI` cycles after it.
- R11: A pending refresh takes priority over a power-down request that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_req | input | 1 | Controller request for one auto refresh |
| pd_req | input | 1 | Request to leave the active state |
| pd_deep | input | 1 | With `pd_req`: 1 selects self refresh, 0 selects power down |
| wake_req | input | 1 | Request to leave power down or self refresh |
| banks_idle | input | 1 | All banks are precharged |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | SDRAM row strobe, active low |
| cas_n | output | 1 | SDRAM column strobe, active low |
| we_n | output | 1 | SDRAM write enable, active low |
| ready | output | 1 | Access commands are allowed |

## Verification
The assertions check on every cycle that `cke` held low carries only NOP, that `ready` implies `cke` high, and that an auto refresh leaves the idle state only when the row-cycle timer is spent. They also check that every drop of `cke` was preceded by a settled precharge, and that a refresh due during power down raises `cke` on the next cycle. The exact cycle counts need the bench's scenarios: the refresh period, the `T_RP`+1 entry delay after the banks settle, the one-cycle and `T_RC`-cycle exit latencies, the forced-exit gap, and the handling of requests that are held, ignored or outranked.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCW,
    ST_PD,
    ST_PDX,
    ST_SR
  } seq_st_e;

  // Command pins in the order chip select, row strobe, column strobe, write enable.
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sdram_ref_interval.sv
module sdram_ref_interval #(
  parameter int T_REFI = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic due
);
  localparam int W = (T_REFI > 2) ? $clog2(T_REFI) : 1;
  localparam logic [W-1:0] LIM = W'(T_REFI - 1);

  logic [W-1:0] cnt_q, cnt_nx;

  assign due = (cnt_q == LIM);

  always_comb begin
    if (clr)      cnt_nx = '0;
    else if (due) cnt_nx = cnt_q;
    else          cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  // R5: once raised, the due flag stays until a refresh clears it
  a_r5_due_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !clr) |=> due);

endmodule

// File: rtl/sdram_pre_settle.sv
module sdram_pre_settle #(
  parameter int T_RP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  output logic settled
);
  localparam int W = $clog2(T_RP + 1);
  localparam logic [W-1:0] LIM = W'(T_RP);

  logic [W-1:0] cnt_q, cnt_nx;

  assign settled = (cnt_q == LIM);

  always_comb begin
    if (!banks_idle)  cnt_nx = '0;
    else if (settled) cnt_nx = cnt_q;
    else              cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  // R6: a bank leaving the precharged state voids the settle credit at once
  a_r6_settle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !banks_idle |=> !settled);

endmodule

// File: rtl/sdram_rc_timer.sv
module sdram_rc_timer #(
  parameter int T_RC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int W = (T_RC > 1) ? $clog2(T_RC) : 1;
  localparam logic [W-1:0] LDV = W'(T_RC - 1);

  logic [W-1:0] cnt_q, cnt_nx;

  assign done = (cnt_q == '0);

  always_comb begin
    if (load)       cnt_nx = LDV;
    else if (!done) cnt_nx = cnt_q - 1'b1;
    else            cnt_nx = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  // R4: a new row-cycle window never starts before the last one ends
  a_r4_no_early_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> done);

endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
  import sdram_seq_pkg::*;
#(
  parameter int T_RC   = 9,
  parameter int T_RP   = 3,
  parameter int T_REFI = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_req,
  input  logic pd_req,
  input  logic pd_deep,
  input  logic wake_req,
  input  logic banks_idle,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready
);

  seq_st_e st_q, st_nx;
  cmd_t    cmd_q, cmd_nx;
  logic    cke_q, cke_nx;
  logic    ready_q, ready_nx;
  logic    ref_lat_q, ref_lat_nx;
  logic    due, settled, rc_done;
  logic    issue_ref, rc_load, ivl_clr, pend;

  assign ivl_clr = issue_ref || (st_q == ST_SR);
  assign pend    = ref_lat_q || ref_req || due;

  sdram_ref_interval #(.T_REFI(T_REFI)) u_ivl (
    .clk(clk), .rst_n(rst_n), .clr(ivl_clr), .due(due)
  );

  sdram_pre_settle #(.T_RP(T_RP)) u_settle (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .settled(settled)
  );

  sdram_rc_timer #(.T_RC(T_RC)) u_rc (
    .clk(clk), .rst_n(rst_n), .load(rc_load), .done(rc_done)
  );

  always_comb begin
    st_nx     = st_q;
    cke_nx    = cke_q;
    cmd_nx    = CMD_NOP;
    issue_ref = 1'b0;
    rc_load   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pend && settled) begin
          issue_ref = 1'b1;
          rc_load   = 1'b1;
          cmd_nx    = CMD_REF;
          st_nx     = ST_RCW;
        end else if (pd_req && settled && !pend) begin
          cke_nx = 1'b0;
          if (pd_deep) begin
            cmd_nx = CMD_REF;
            st_nx  = ST_SR;
          end else begin
            st_nx  = ST_PD;
          end
        end
      end
      ST_RCW: begin
        if (rc_done) st_nx = ST_IDLE;
      end
      ST_PD: begin
        if (wake_req || pend) begin
          cke_nx = 1'b1;
          st_nx  = ST_PDX;
        end
      end
      ST_PDX: begin
        st_nx = ST_IDLE;
      end
      ST_SR: begin
        if (wake_req) begin
          cke_nx  = 1'b1;
          rc_load = 1'b1;
          st_nx   = ST_RCW;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    ready_nx = (st_nx == ST_IDLE);
    if (st_q == ST_SR || issue_ref) ref_lat_nx = 1'b0;
    else                            ref_lat_nx = ref_lat_q || ref_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cke_q     <= 1'b1;
      cmd_q     <= CMD_DESEL;
      ready_q   <= 1'b0;
      ref_lat_q <= 1'b0;
    end else begin
      st_q      <= st_nx;
      cke_q     <= cke_nx;
      cmd_q     <= cmd_nx;
      ready_q   <= ready_nx;
      ref_lat_q <= ref_lat_nx;
    end
  end

  assign cke   = cke_q;
  assign cs_n  = cmd_q.cs_n;
  assign ras_n = cmd_q.ras_n;
  assign cas_n = cmd_q.cas_n;
  assign we_n  = cmd_q.we_n;
  assign ready = ready_q;

  // R2: clock enable held low carries only NOP
  a_r2_nop_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_q && $past(!cke_q)) |-> (cmd_q == CMD_NOP));

  // R4: an auto refresh leaves from a state where access was allowed
  a_r4_ref_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF && cke_q) |-> $past(ready_q));

  // R6: every drop of clock enable follows a settled precharge
  a_r6_entry_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_q) |-> $past(settled));

  // R7: ready only with clock enable high
  a_r7_ready_cke: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> cke_q);

  // R8: a due refresh wakes a powered-down memory
  a_r8_due_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PD && due) |=> cke_q);

  // R9: the self-refresh entry command lasts one cycle
  a_r9_sr_single: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF && !cke_q) |=> (cmd_q == CMD_NOP));

endmodule

// File: tb/tb_sdram_pwr_seq.sv
module tb_sdram_pwr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int T_RC   = 6;
  localparam int T_RP   = 3;
  localparam int T_REFI = 120;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_req, pd_req, pd_deep, wake_req, banks_idle;
  logic cke, cs_n, ras_n, cas_n, we_n, ready;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_ref = -100000;
  int last_rc_ev = -100000;
  int idle_run = 0;
  logic prev_cke = 1'b1;
  logic in_sr = 1'b0;
  bit   mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_pwr_seq #(.T_RC(T_RC), .T_RP(T_RP), .T_REFI(T_REFI)) dut (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .pd_req(pd_req),
    .pd_deep(pd_deep), .wake_req(wake_req), .banks_idle(banks_idle),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ready(ready)
  );

  function automatic int exp_pd_entry_ticks();
    return T_RP + 1;
  endfunction

  function automatic int exp_forced_gap();
    return T_REFI + 2;
  endfunction

  function automatic bit is_ref();
    return (cs_n == 1'b0 && ras_n == 1'b0 && cas_n == 1'b0 && we_n == 1'b1);
  endfunction

  function automatic bit is_nop();
    return (cs_n == 1'b0 && ras_n == 1'b1 && cas_n == 1'b1 && we_n == 1'b1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic monitor();
    chk(cs_n == 1'b0, "R1 cs_n low after reset", int'(cs_n), 0);
    if (!cke && !prev_cke) chk(is_nop(), "R2 NOP while cke low", int'({cs_n, ras_n, cas_n, we_n}), 7);
    if (is_ref() && cke) begin
      chk(cyc - last_rc_ev >= T_RC, "R4 refresh spacing", cyc - last_rc_ev, T_RC);
      last_ref   = cyc;
      last_rc_ev = cyc;
    end
    if (!cke && prev_cke) begin
      chk(idle_run >= T_RP, "R6 entry after settle", idle_run, T_RP);
      if (is_ref()) in_sr = 1'b1;
    end
    if (cke && !prev_cke && in_sr) begin
      last_rc_ev = cyc;
      in_sr      = 1'b0;
    end
    if (ready) begin
      chk(cke == 1'b1, "R7 ready implies cke", int'(cke), 1);
      chk(cyc - last_rc_ev >= T_RC, "R4 ready after row cycle", cyc - last_rc_ev, T_RC);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (mon_on) monitor();
    prev_cke = cke;
    idle_run = banks_idle ? idle_run + 1 : 0;
  endtask

  task automatic wait_ready();
    while (!ready) tick();
  endtask

  initial begin
    int r0;
    int t0;
    int e0;
    int w;
    rst_n = 1'b0; ref_req = 1'b0; pd_req = 1'b0; pd_deep = 1'b0;
    wake_req = 1'b0; banks_idle = 1'b1;
    repeat (3) @(negedge clk);
    chk(cke == 1'b1 && cs_n == 1'b1 && ras_n == 1'b1 && cas_n == 1'b1 && we_n == 1'b1,
        "R1 reset pins", int'({cke, cs_n, ras_n, cas_n, we_n}), 31);
    chk(ready == 1'b0, "R1 reset ready", int'(ready), 0);
    rst_n = 1'b1;
    cyc = 0;
    mon_on = 1'b1;

    // R5: first and second self-initiated refresh
    while (!(is_ref() && cke) && cyc < 4 * T_REFI) tick();
    chk(cyc == T_REFI, "R5 first refresh", cyc, T_REFI);
    r0 = cyc;
    tick();
    while (!(is_ref() && cke) && cyc < r0 + 4 * T_REFI) tick();
    chk(cyc - r0 == T_REFI, "R5 refresh period", cyc - r0, T_REFI);

    // R3 + R4: requested refresh and ready window
    wait_ready();
    ref_req = 1'b1;
    tick();
    ref_req = 1'b0;
    chk(is_ref() && cke, "R3 refresh on request", int'(is_ref()), 1);
    r0 = cyc;
    repeat (T_RC - 1) tick();
    chk(ready == 1'b0, "R4 ready low at T_RC-1", int'(ready), 0);
    tick();
    chk(ready == 1'b1, "R4 ready high at T_RC", int'(ready), 1);

    // R3: request while busy is held
    ref_req = 1'b1;
    tick();
    ref_req = 1'b0;
    r0 = cyc;
    chk(is_ref() && cke, "R3 immediate refresh", int'(is_ref()), 1);
    ref_req = 1'b1;
    tick();
    ref_req = 1'b0;
    while (!(is_ref() && cke) && cyc < r0 + 4 * T_RC) tick();
    chk(cyc - r0 == T_RC + 1, "R3 held refresh", cyc - r0, T_RC + 1);
    r0 = cyc;

    // R6 + R7: power down and wake
    wait_ready();
    pd_req = 1'b1;
    tick();
    pd_req = 1'b0;
    chk(cke == 1'b0 && is_nop(), "R6 power-down entry", int'(cke), 0);
    repeat (8) begin
      tick();
      chk(cke == 1'b0, "R6 stays powered down", int'(cke), 0);
    end
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    chk(cke == 1'b1 && ready == 1'b0, "R7 wake raises cke", int'({cke, ready}), 2);
    tick();
    chk(ready == 1'b1, "R7 ready one cycle later", int'(ready), 1);

    // R6: entry delayed until banks settle, then R8 forced exit
    banks_idle = 1'b0;
    tick(); tick();
    banks_idle = 1'b1;
    pd_req = 1'b1;
    t0 = cyc;
    while (cke && cyc < t0 + 20) tick();
    pd_req = 1'b0;
    chk(cyc - t0 == exp_pd_entry_ticks(), "R6 settle delay", cyc - t0, exp_pd_entry_ticks());
    while (!cke && cyc < r0 + 3 * T_REFI) tick();
    chk(cyc - r0 == T_REFI, "R8 forced wake", cyc - r0, T_REFI);
    while (!(is_ref() && cke) && cyc < r0 + 3 * T_REFI) tick();
    chk(cyc - r0 == exp_forced_gap(), "R8 refresh after forced wake", cyc - r0, exp_forced_gap());

    // R11: pending refresh beats power-down request
    wait_ready();
    ref_req = 1'b1;
    pd_req  = 1'b1;
    tick();
    ref_req = 1'b0;
    chk(is_ref() && cke, "R11 refresh first", int'({cke, is_ref()}), 3);
    r0 = cyc;
    while (cke && cyc < r0 + 20) tick();
    pd_req = 1'b0;
    chk(cyc - r0 == T_RC + 1, "R11 power down after refresh", cyc - r0, T_RC + 1);
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    wait_ready();

    // R9 + R10: self refresh
    pd_req  = 1'b1;
    pd_deep = 1'b1;
    tick();
    pd_req  = 1'b0;
    pd_deep = 1'b0;
    chk(cke == 1'b0 && is_ref(), "R9 self-refresh entry", int'({cke, is_ref()}), 1);
    tick();
    chk(cke == 1'b0 && is_nop(), "R9 NOP after entry", int'({cke, is_nop()}), 1);
    ref_req = 1'b1;
    tick();
    ref_req = 1'b0;
    w = 0;
    repeat (2 * T_REFI) begin
      tick();
      if (cke) w++;
    end
    chk(w == 0, "R9 no wake by interval or request", w, 0);
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    e0 = cyc;
    chk(cke == 1'b1 && ready == 1'b0, "R10 exit raises cke", int'({cke, ready}), 2);
    repeat (T_RC - 1) tick();
    chk(ready == 1'b0, "R10 ready low at T_RC-1", int'(ready), 0);
    tick();
    chk(ready == 1'b1, "R10 ready after T_RC", int'(ready), 1);
    while (!(is_ref() && cke) && cyc < e0 + 3 * T_REFI) tick();
    chk(cyc - e0 == T_REFI, "R10 interval restarts", cyc - e0, T_REFI);

    // Random phase, checked by the per-cycle monitor
    void'($urandom(32'h5eed_1234));
    repeat (4000) begin
      tick();
      banks_idle = ($urandom_range(0, 9) != 0);
      ref_req    = ($urandom_range(0, 19) == 0);
      pd_req     = ($urandom_range(0, 9) == 0);
      pd_deep    = ($urandom_range(0, 2) == 0);
      wake_req   = ($urandom_range(0, 11) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d: actual hang expected finish", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule